// File: doc/BRIEF.md
# Register Rename and Status Table

This block keeps one entry per architectural register for an out-of-order core. Each entry records whether the register's committed value is current or is still being produced by an instruction held in the reorder buffer. When it is not current, the entry holds the reorder-buffer index (the tag) of the youngest instruction that writes the register. At dispatch, two source read ports give each operand either as a ready value or as the tag the consumer must wait for. In the same cycle the destination register is marked pending on the newly allocated tag.

At retire, the reorder buffer hands back the destination register, the tag of the retiring instruction and its result. The result always goes into the register's value field. The register becomes current again only if the retiring tag is still the latest writer recorded for it, so an older instruction that retires behind a younger rename leaves the register pending. The reorder buffer and the execution units sit outside this block.

Top module: `reg_status_table`

## Requirements
- R1: After reset every register reads as ready with value zero.
- R2: A read of a ready register returns ready=1, its stored value, and tag 0.
- R3: A read of a pending register returns ready=0, the stored tag, and value 0.
- R4: A dispatch with enable set makes its destination register pending on the given tag from the next cycle on.
- R5: A retire always writes its value into the destination register's value field. On a register that is already ready, the new value reads back from the next cycle on.
- R6: A retire whose tag equals the pending register's stored tag makes the register ready with the retired value.
- R7: A retire whose tag differs from the pending register's stored tag leaves it pending with the stored tag unchanged.
- R8: When dispatch and retire name the same register in one cycle, the register ends pending on the dispatch tag, whether or not the retiring tag matched.
- R9: Reads return the state from before the same cycle's dispatch and retire. A source that equals the destination of the same dispatch sees the old state.
- R10: The two read ports are independent and may address the same register in one cycle. A cycle with no dispatch and no retire changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_idx | input | IDX_W | Register read by port A |
| src_a_ready | output | 1 | Port A operand is ready |
| src_a_value | output | DATA_W | Port A value when ready, else 0 |
| src_a_tag | output | TAG_W | Port A producer tag when pending, else 0 |
| src_b_idx | input | IDX_W | Register read by port B |
| src_b_ready | output | 1 | Port B operand is ready |
| src_b_value | output | DATA_W | Port B value when ready, else 0 |
| src_b_tag | output | TAG_W | Port B producer tag when pending, else 0 |
| disp_en | input | 1 | Dispatch renames a destination this cycle |
| disp_dest | input | IDX_W | Destination register of the dispatch |
| disp_tag | input | TAG_W | Reorder-buffer index allocated to it |
| ret_en | input | 1 | An instruction retires this cycle |
| ret_dest | input | IDX_W | Destination register of the retiring instruction |
| ret_tag | input | TAG_W | Reorder-buffer index of the retiring instruction |
| ret_value | input | DATA_W | Result being committed |

## Verification
Dispatch and retire can both fall in one cycle on the same register, and that collision is where the priority rule matters. The bench provokes it in two ways. In a directed case, a register is pending on tag T, and then T retires in the same cycle that a new dispatch renames that register. It also happens at random, because both ports draw destinations from a small register set. The result is judged on the following cycle through the read ports: the register must read pending on the dispatch tag. A reference model then tracks the retired value until a later matching retire exposes it.

// File: rtl/rst_pkg.sv
package rst_pkg;

  // Kind of update seen by one register entry in a cycle; encoding is
  // {dispatch hit, retire hit}.
  typedef enum logic [1:0] {
    UPD_NONE = 2'b00,
    UPD_RET  = 2'b01,
    UPD_DISP = 2'b10,
    UPD_BOTH = 2'b11
  } upd_kind_e;

endpackage

// File: rtl/rst_onehot_dec.sv
module rst_onehot_dec #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     hit
);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit[i] = en && (idx == IDX_W'(i));
    end
  end

endmodule

// File: rtl/rst_entry.sv
module rst_entry
  import rst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_hit,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic              ret_hit,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_value,
  output logic              valid_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] value_q
);

  upd_kind_e         kind;
  logic              tag_match;
  logic              valid_d;
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] value_d;
  logic              state_en;
  logic              value_en;

  always_comb begin
    kind      = upd_kind_e'({disp_hit, ret_hit});
    tag_match = !valid_q && (tag_q == ret_tag);
    valid_d   = valid_q;
    tag_d     = tag_q;
    value_d   = value_q;
    unique case (kind)
      UPD_RET: begin
        value_d = ret_value;
        if (tag_match) begin
          valid_d = 1'b1;
        end
      end
      UPD_DISP: begin
        valid_d = 1'b0;
        tag_d   = disp_tag;
      end
      UPD_BOTH: begin
        value_d = ret_value;
        valid_d = 1'b0;
        tag_d   = disp_tag;
      end
      default: begin
      end
    endcase
    state_en = disp_hit || ret_hit;
    value_en = ret_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b1;
      tag_q   <= '0;
      value_q <= '0;
    end else begin
      if (state_en) begin
        valid_q <= valid_d;
        tag_q   <= tag_d;
      end
      if (value_en) begin
        value_q <= value_d;
      end
    end
  end

endmodule

// File: rtl/rst_read_port.sv
module rst_read_port #(
  parameter int N      = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]             valid_vec,
  input  logic [N-1:0][TAG_W-1:0]  tag_vec,
  input  logic [N-1:0][DATA_W-1:0] value_vec,
  input  logic [IDX_W-1:0]         idx,
  output logic                     ready,
  output logic [DATA_W-1:0]        value,
  output logic [TAG_W-1:0]         tag
);

  logic              sel_valid;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_value;

  always_comb begin
    sel_valid = 1'b0;
    sel_tag   = '0;
    sel_value = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) begin
        sel_valid = valid_vec[i];
        sel_tag   = tag_vec[i];
        sel_value = value_vec[i];
      end
    end
    ready = sel_valid;
    value = sel_valid ? sel_value : '0;
    tag   = sel_valid ? '0 : sel_tag;
  end

endmodule

// File: rtl/reg_status_table.sv
module reg_status_table #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 5,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  src_a_idx,
  output logic              src_a_ready,
  output logic [DATA_W-1:0] src_a_value,
  output logic [TAG_W-1:0]  src_a_tag,
  input  logic [IDX_W-1:0]  src_b_idx,
  output logic              src_b_ready,
  output logic [DATA_W-1:0] src_b_value,
  output logic [TAG_W-1:0]  src_b_tag,
  input  logic              disp_en,
  input  logic [IDX_W-1:0]  disp_dest,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic              ret_en,
  input  logic [IDX_W-1:0]  ret_dest,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_value
);

  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0]             disp_hit;
  logic [NUM_REGS-1:0]             ret_hit;
  logic [NUM_REGS-1:0]             ent_valid;
  logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag;
  logic [NUM_REGS-1:0][DATA_W-1:0] ent_value;

  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0]               rd_ready;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_value;
  logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag;

  rst_onehot_dec #(.N(NUM_REGS), .IDX_W(IDX_W)) u_disp_dec (
    .en  (disp_en),
    .idx (disp_dest),
    .hit (disp_hit)
  );

  rst_onehot_dec #(.N(NUM_REGS), .IDX_W(IDX_W)) u_ret_dec (
    .en  (ret_en),
    .idx (ret_dest),
    .hit (ret_hit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    rst_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .disp_hit  (disp_hit[g]),
      .disp_tag  (disp_tag),
      .ret_hit   (ret_hit[g]),
      .ret_tag   (ret_tag),
      .ret_value (ret_value),
      .valid_q   (ent_valid[g]),
      .tag_q     (ent_tag[g]),
      .value_q   (ent_value[g])
    );
  end

  assign rd_idx[0] = src_a_idx;
  assign rd_idx[1] = src_b_idx;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rst_read_port #(
      .N(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) u_rd (
      .valid_vec (ent_valid),
      .tag_vec   (ent_tag),
      .value_vec (ent_value),
      .idx       (rd_idx[p]),
      .ready     (rd_ready[p]),
      .value     (rd_value[p]),
      .tag       (rd_tag[p])
    );
  end

  assign src_a_ready = rd_ready[0];
  assign src_a_value = rd_value[0];
  assign src_a_tag   = rd_tag[0];
  assign src_b_ready = rd_ready[1];
  assign src_b_value = rd_value[1];
  assign src_b_tag   = rd_tag[1];

endmodule

// File: rtl/rst_checker.sv
module rst_checker #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 5,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            disp_en,
  input logic [IDX_W-1:0]                disp_dest,
  input logic [TAG_W-1:0]                disp_tag,
  input logic                            ret_en,
  input logic [IDX_W-1:0]                ret_dest,
  input logic [TAG_W-1:0]                ret_tag,
  input logic [DATA_W-1:0]               ret_value,
  input logic [NUM_REGS-1:0]             ent_valid,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag,
  input logic [NUM_REGS-1:0][DATA_W-1:0] ent_value
);

  logic same_reg;
  logic ret_match;
  assign same_reg  = disp_en && ret_en && (disp_dest == ret_dest);
  assign ret_match = !ent_valid[ret_dest] && (ent_tag[ret_dest] == ret_tag);

  AST_DISP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |=> !ent_valid[$past(disp_dest)] &&
                ent_tag[$past(disp_dest)] == $past(disp_tag)); // R4

  AST_RET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |=> ent_value[$past(ret_dest)] == $past(ret_value)); // R5

  AST_RET_MATCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && ret_match && !same_reg) |=> ent_valid[$past(ret_dest)]); // R6

  AST_RET_STALE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !ent_valid[ret_dest] && !ret_match && !same_reg) |=>
      !ent_valid[$past(ret_dest)] &&
      ent_tag[$past(ret_dest)] == $past(ent_tag[ret_dest])); // R7

  AST_BOTH_DISP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    same_reg |=> !ent_valid[$past(disp_dest)] &&
                 ent_tag[$past(disp_dest)] == $past(disp_tag)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && !ret_en) |=>
      $stable(ent_valid) && $stable(ent_tag) && $stable(ent_value)); // R10

endmodule

bind reg_status_table rst_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) i_rst_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_en   (disp_en),
  .disp_dest (disp_dest),
  .disp_tag  (disp_tag),
  .ret_en    (ret_en),
  .ret_dest  (ret_dest),
  .ret_tag   (ret_tag),
  .ret_value (ret_value),
  .ent_valid (ent_valid),
  .ent_tag   (ent_tag),
  .ent_value (ent_value)
);

// File: tb/test_reg_status_table.sv
`timescale 1ns/100ps
module test_reg_status_table;

  localparam int NUM_REGS = 16;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 5;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic              clk;
  logic              rst_n;
  logic [IDX_W-1:0]  src_a_idx, src_b_idx;
  logic              src_a_ready, src_b_ready;
  logic [DATA_W-1:0] src_a_value, src_b_value;
  logic [TAG_W-1:0]  src_a_tag, src_b_tag;
  logic              disp_en, ret_en;
  logic [IDX_W-1:0]  disp_dest, ret_dest;
  logic [TAG_W-1:0]  disp_tag, ret_tag;
  logic [DATA_W-1:0] ret_value;

  int checks = 0;
  int fails  = 0;

  logic              m_valid [NUM_REGS];
  logic [TAG_W-1:0]  m_tag   [NUM_REGS];
  logic [DATA_W-1:0] m_value [NUM_REGS];

  reg_status_table #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W))
    i_reg_status_table (
      .clk(clk), .rst_n(rst_n),
      .src_a_idx(src_a_idx), .src_a_ready(src_a_ready),
      .src_a_value(src_a_value), .src_a_tag(src_a_tag),
      .src_b_idx(src_b_idx), .src_b_ready(src_b_ready),
      .src_b_value(src_b_value), .src_b_tag(src_b_tag),
      .disp_en(disp_en), .disp_dest(disp_dest), .disp_tag(disp_tag),
      .ret_en(ret_en), .ret_dest(ret_dest), .ret_tag(ret_tag),
      .ret_value(ret_value)
    );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk_port(input string req, input string port, input int idx,
                          input logic rdy, input logic [DATA_W-1:0] val,
                          input logic [TAG_W-1:0] tg);
    logic              e_rdy;
    logic [DATA_W-1:0] e_val;
    logic [TAG_W-1:0]  e_tag;
    string             r;
    e_rdy = m_valid[idx];
    e_val = e_rdy ? m_value[idx] : '0;
    e_tag = e_rdy ? '0 : m_tag[idx];
    r = (req == "") ? (e_rdy ? "R2" : "R3") : req;
    checks++;
    if (rdy !== e_rdy || val !== e_val || tg !== e_tag) begin
      fails++;
      $display("FAIL %s port %s reg %0d: actual rdy=%0b val=%h tag=%0d expected rdy=%0b val=%h tag=%0d",
               r, port, idx, rdy, val, tg, e_rdy, e_val, e_tag);
    end
  endtask

  // One cycle: drive at the falling edge, check reads against the model
  // state before the edge, then apply the update to the model.
  task automatic step(input logic de, input int dd, input int dt,
                      input logic re, input int rd, input int rt,
                      input logic [DATA_W-1:0] rv,
                      input int ia, input int ib, input string req);
    @(negedge clk);
    disp_en = de; disp_dest = IDX_W'(dd); disp_tag = TAG_W'(dt);
    ret_en = re; ret_dest = IDX_W'(rd); ret_tag = TAG_W'(rt); ret_value = rv;
    src_a_idx = IDX_W'(ia); src_b_idx = IDX_W'(ib);
    #1;
    chk_port(req, "A", ia, src_a_ready, src_a_value, src_a_tag);
    chk_port(req, "B", ib, src_b_ready, src_b_value, src_b_tag);
    @(posedge clk);
    if (re) begin
      m_value[rd] = rv;
      if (!m_valid[rd] && m_tag[rd] == TAG_W'(rt)) m_valid[rd] = 1'b1;
    end
    if (de) begin
      m_valid[dd] = 1'b0;
      m_tag[dd]   = TAG_W'(dt);
    end
  endtask

  task automatic idle_read(input int ia, input int ib, input string req);
    step(1'b0, 0, 0, 1'b0, 0, 0, '0, ia, ib, req);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    disp_en = 1'b0; disp_dest = '0; disp_tag = '0;
    ret_en = 1'b0; ret_dest = '0; ret_tag = '0; ret_value = '0;
    src_a_idx = '0; src_b_idx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      m_valid[i] = 1'b1; m_tag[i] = '0; m_value[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, both ports on the same register (R10)
    for (int r = 0; r < NUM_REGS; r++) idle_read(r, r, "R1");

    // R4 then R3: dispatch renames reg 3 on tag 7
    step(1'b1, 3, 7, 1'b0, 0, 0, '0, 0, 1, "R10");
    idle_read(3, 3, "R4");
    // R6: matching retire makes it ready with the value
    step(1'b0, 0, 0, 1'b1, 3, 7, 32'hAAAA_0003, 3, 4, "R3");
    idle_read(3, 4, "R6");
    // R5: retire to an already ready register
    step(1'b0, 0, 0, 1'b1, 5, 9, 32'h0000_0055, 5, 5, "R2");
    idle_read(5, 3, "R5");
    // R7: older writer retires after a younger rename
    step(1'b1, 2, 1, 1'b0, 0, 0, '0, 2, 2, "R10");
    step(1'b1, 2, 2, 1'b0, 0, 0, '0, 2, 2, "R3");
    step(1'b0, 0, 0, 1'b1, 2, 1, 32'h1111_1111, 2, 2, "R3");
    idle_read(2, 2, "R7");
    step(1'b0, 0, 0, 1'b1, 2, 2, 32'h2222_2222, 2, 2, "R7");
    idle_read(2, 2, "R6");
    // R8: retire of the pending tag and a new rename on the same register
    step(1'b1, 4, 3, 1'b0, 0, 0, '0, 4, 4, "R2");
    step(1'b1, 4, 9, 1'b1, 4, 3, 32'h4444_0004, 4, 4, "R3");
    idle_read(4, 4, "R8");
    step(1'b0, 0, 0, 1'b1, 4, 9, 32'h4444_0009, 4, 4, "R8");
    idle_read(4, 0, "R6");
    // R9: source equal to the destination of the same dispatch
    step(1'b1, 6, 11, 1'b0, 0, 0, '0, 6, 6, "R9");
    idle_read(6, 6, "R4");
    // R9: read in the cycle of a matching retire still sees pending
    step(1'b0, 0, 0, 1'b1, 6, 11, 32'h6666_0006, 6, 6, "R9");
    idle_read(6, 6, "R6");

    // Random phase over a small register window to force collisions
    for (int n = 0; n < 3000; n++) begin
      int dd, rd, dt, rt, ia, ib;
      logic de, re;
      dd = int'($urandom_range(0, 5));
      rd = int'($urandom_range(0, 5));
      de = ($urandom_range(0, 1) == 1);
      re = ($urandom_range(0, 1) == 1);
      dt = int'($urandom_range(0, (1 << TAG_W) - 1));
      rt = ($urandom_range(0, 3) != 0) ? int'(m_tag[rd])
                                       : int'($urandom_range(0, (1 << TAG_W) - 1));
      ia = ($urandom_range(0, 3) == 0) ? dd : int'($urandom_range(0, NUM_REGS - 1));
      ib = int'($urandom_range(0, 5));
      step(de, dd, dt, re, rd, rt, DATA_W'($urandom), ia, ib, "");
    end
    for (int r = 0; r < NUM_REGS; r++) idle_read(r, NUM_REGS - 1 - r, "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule